// File: doc/BRIEF.md
# Windowed I/O Address Translator

This block sits between a CPU load/store port and a 16-bit I/O address space. CPU accesses land in an 8 MB window at CPU address 0x80000000. The block turns each one into a single downstream I/O transaction. A mode input picks one of two translation schemes. In the dense scheme the low 16 address bits pass straight through. In the sparse scheme the page-number field of the CPU address is folded down so that it sits next to a 5-bit offset, which lets software give each I/O port group its own 4 KB page.

Data passes through a lane stage in both directions. A big-endian CPU sees half-words with their two bytes exchanged and words with all four bytes reversed. Single bytes always go through unchanged.

The block also owns a small 4-byte region at 0xBFFFFFF0. A read at the base address of that region returns the vector that an external interrupt controller presents. The same lane treatment applies to that read, and the block answers it itself in one cycle. Any access outside both regions gets no ready response and raises a one-cycle error flag instead. Only one access is in flight at a time.

Top module: `iowin_bridge`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `io_req`, `cpu_ready` and `cpu_err` are low.
- R2: A request accepted while idle, at an address in [0x80000000, 0x80800000), raises `io_req` in the next cycle. `io_req` stays high with `io_addr` and `io_wdata` unchanged until `io_ack` is sampled high. No `cpu_ready` is given for it before that point.
- R3: With `map_sparse` = 0, `io_addr` equals CPU address bits [15:0].
- R4: With `map_sparse` = 1, `io_addr` is {CPU address bits [22:12], CPU address bits [4:0]}.
- R5: With `big_endian` = 0, data in both directions is masked by size and not reordered. Size code 0 (byte) keeps bits [7:0], code 1 (half) keeps bits [15:0], and code 2 (word) or the reserved code 3 keeps all 32 bits. Masked-off bits read as zero.
- R6: With `big_endian` = 1, a half access presents {bits[7:0], bits[15:8]} in the low 16 bits and zero above. A word access presents the four bytes in reverse order. A byte access behaves as in R5. This holds for write data and for read data alike.
- R7: After `io_ack` is sampled high, `cpu_ready` is high for exactly the next cycle, and `io_req` is low in that cycle. For a read, `cpu_rdata` carries `io_rdata` processed per R5/R6 under the size and byte order of the request.
- R8: A read at 0xBFFFFFF0 gives `cpu_ready` in the cycle after acceptance. `cpu_rdata` carries `iack_vec`, zero-extended and processed per R5/R6. `io_req` stays low.
- R9: Reads at 0xBFFFFFF1 to 0xBFFFFFF3 return zero with a ready pulse. Writes anywhere in 0xBFFFFFF0 to 0xBFFFFFF3 return a ready pulse and start no I/O access.
- R10: A request outside both regions gives a one-cycle `cpu_err` in the cycle after acceptance, with no `cpu_ready` and no `io_req`.
- R11: A `cpu_req` arriving while an I/O access is outstanding is ignored. It starts no second access and adds no extra ready pulse.
- R12: `io_we` and `io_size` carry the write flag and size code of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sparse | input | 1 | 0: dense translation, 1: sparse page folding |
| big_endian | input | 1 | CPU byte order, 1 = big-endian lane swap |
| cpu_req | input | 1 | Request strobe, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 half, 2 word, 3 treated as word |
| cpu_addr | input | 32 | CPU address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | One-cycle pulse for an unmapped address |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| io_req | output | 1 | Downstream access request, held until acknowledged |
| io_we | output | 1 | Downstream write flag |
| io_size | output | 2 | Downstream size code |
| io_addr | output | 16 | Translated I/O address |
| io_wdata | output | 32 | Lane-processed write data |
| io_ack | input | 1 | Downstream completion, sampled while `io_req` is high |
| io_rdata | input | 32 | Downstream read data, valid with `io_ack` |
| iack_vec | input | 8 | Vector from the interrupt controller |

## Verification
The bench builds the block with its default parameters: a 32-bit address and data path, a 16-bit I/O space with a 5-bit sparse offset, and an 8-bit vector. With these values the window edge at 0x80800000 and the last page of the sparse fold can be reached directly by address. The two neighbours of the acknowledge region, 0xBFFFFFEF and 0xBFFFFFF4, can be reached the same way. Random addresses inside the window, together with random sizes, byte orders, modes and acknowledge delays, cover every combination of translation scheme and lane treatment. Stray requests during long acknowledge delays exercise the single-outstanding rule.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_IOWIN = 2'd1,
    RGN_IACK  = 2'd2
  } region_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_IO   = 1'b1
  } bridge_state_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
  import iowin_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                WIN_LOG2  = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter int                IACK_LOG2 = 2,
  parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              iack_exact
);

  logic hit_win;
  logic hit_iack;

  assign hit_win    = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign hit_iack   = (addr[ADDR_W-1:IACK_LOG2] == IACK_ADDR[ADDR_W-1:IACK_LOG2]);
  assign iack_exact = hit_iack && (addr[IACK_LOG2-1:0] == IACK_ADDR[IACK_LOG2-1:0]);

  always_comb begin
    if (hit_win)       region = RGN_IOWIN;
    else if (hit_iack) region = RGN_IACK;
    else               region = RGN_NONE;
  end

endmodule

// File: rtl/iowin_addr_xlate.sv
module iowin_addr_xlate #(
  parameter int IO_W  = 16,
  parameter int OFS_W = 5,
  localparam int PAGE_W = IO_W - OFS_W
) (
  input  logic              sparse,
  input  logic [IO_W-1:0]   low_field,
  input  logic [PAGE_W-1:0] page_field,
  output logic [IO_W-1:0]   io_addr
);

  logic [IO_W-1:0] folded;

  // Page number lands just above the in-page offset.
  assign folded  = {page_field, low_field[OFS_W-1:0]};
  assign io_addr = sparse ? folded : low_field;

endmodule

// File: rtl/iowin_lane_swap.sv
module iowin_lane_swap
  import iowin_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              big_endian,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] rev_all;
  logic [DATA_W-1:0] half_le;
  logic [DATA_W-1:0] half_be;
  logic [DATA_W-1:0] byte_only;

  for (genvar g = 0; g < BYTES; g++) begin : g_rev
    assign rev_all[g*8 +: 8] = din[(BYTES-1-g)*8 +: 8];
  end

  assign byte_only = {{(DATA_W-8){1'b0}},  din[7:0]};
  assign half_le   = {{(DATA_W-16){1'b0}}, din[15:0]};
  assign half_be   = {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]};

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: dout = byte_only;
      SZ_HALF: dout = big_endian ? half_be : half_le;
      default: dout = big_endian ? rev_all : din;
    endcase
  end

endmodule

// File: rtl/iowin_bridge.sv
module iowin_bridge
  import iowin_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                IO_W      = 16,
  parameter int                OFS_W     = 5,
  parameter int                PAGE_LSB  = 12,
  parameter int                WIN_LOG2  = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] IACK_ADDR = 32'hBFFF_FFF0,
  parameter int                VEC_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_sparse,
  input  logic              big_endian,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_err,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_req,
  output logic              io_we,
  output logic [1:0]        io_size,
  output logic [IO_W-1:0]   io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic              io_ack,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [VEC_W-1:0]  iack_vec
);

  localparam int PAGE_W   = IO_W - OFS_W;
  localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

  bridge_state_e     state;
  region_e           region;
  logic              iack_exact;
  logic              be_q;
  logic [IO_W-1:0]   xl_addr;
  logic [DATA_W-1:0] wr_lane;
  logic [DATA_W-1:0] rd_src;
  logic [1:0]        rd_size;
  logic              rd_be;
  logic [DATA_W-1:0] rd_lane;
  logic [DATA_W-1:0] vec_ext;

  assign vec_ext = {{(DATA_W-VEC_W){1'b0}}, iack_vec};

  iowin_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .WIN_BASE  (WIN_BASE),
    .IACK_LOG2 (2),
    .IACK_ADDR (IACK_ADDR)
  ) u_decode (
    .addr       (cpu_addr),
    .region     (region),
    .iack_exact (iack_exact)
  );

  iowin_addr_xlate #(
    .IO_W  (IO_W),
    .OFS_W (OFS_W)
  ) u_xlate (
    .sparse     (map_sparse),
    .low_field  (cpu_addr[IO_W-1:0]),
    .page_field (cpu_addr[PAGE_MSB:PAGE_LSB]),
    .io_addr    (xl_addr)
  );

  iowin_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din        (cpu_wdata),
    .size       (cpu_size),
    .big_endian (big_endian),
    .dout       (wr_lane)
  );

  // Read lane stage is shared between the I/O return and the vector read.
  assign rd_src  = (state == ST_IO) ? io_rdata : vec_ext;
  assign rd_size = (state == ST_IO) ? io_size  : cpu_size;
  assign rd_be   = (state == ST_IO) ? be_q     : big_endian;

  iowin_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din        (rd_src),
    .size       (rd_size),
    .big_endian (rd_be),
    .dout       (rd_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      io_req    <= 1'b0;
      io_we     <= 1'b0;
      io_size   <= 2'd0;
      io_addr   <= '0;
      io_wdata  <= '0;
      be_q      <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_err   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      cpu_err   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            case (region)
              RGN_IOWIN: begin
                io_req   <= 1'b1;
                io_we    <= cpu_we;
                io_size  <= cpu_size;
                io_addr  <= xl_addr;
                io_wdata <= wr_lane;
                be_q     <= big_endian;
                state    <= ST_IO;
              end
              RGN_IACK: begin
                cpu_ready <= 1'b1;
                cpu_rdata <= (!cpu_we && iack_exact) ? rd_lane : '0;
              end
              default: cpu_err <= 1'b1;
            endcase
          end
        end
        ST_IO: begin
          if (io_ack) begin
            io_req    <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= io_we ? '0 : rd_lane;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  ready_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && cpu_err));

  // R10
  err_no_io_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_err) |-> !io_req);

  // R2
  io_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_ack) |=> (io_req && $stable(io_addr) && $stable(io_wdata)));

  // R7
  ack_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_ack) |=> (cpu_ready && !io_req));

  // R3
  dense_map_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_req) && !$past(map_sparse)) |-> (io_addr == $past(cpu_addr[IO_W-1:0])));

  // R4
  sparse_map_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_req) && $past(map_sparse)) |->
      (io_addr == {$past(cpu_addr[PAGE_MSB:PAGE_LSB]), $past(cpu_addr[OFS_W-1:0])}));

endmodule

// File: tb/sim_iowin_bridge.sv
module sim_iowin_bridge;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_sparse = 1'b0;
  logic        big_endian = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic        cpu_err;
  logic [31:0] cpu_rdata;
  logic        io_req;
  logic        io_we;
  logic [1:0]  io_size;
  logic [15:0] io_addr;
  logic [31:0] io_wdata;
  logic        io_ack = 1'b0;
  logic [31:0] io_rdata = '0;
  logic [7:0]  iack_vec = '0;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iowin_bridge u0 (
    .clk(clk), .rst(rst), .map_sparse(map_sparse), .big_endian(big_endian),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
    .cpu_rdata(cpu_rdata), .io_req(io_req), .io_we(io_we), .io_size(io_size),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .iack_vec(iack_vec)
  );

  function automatic logic [15:0] exp_xlate(input logic [31:0] a, input logic sp);
    return sp ? {a[22:12], a[4:0]} : a[15:0];
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] d, input logic [1:0] sz,
                                           input logic be);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic io_access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                           input logic [31:0] wd, input logic [31:0] rd, input int dly,
                           input logic stray);
    logic [15:0] held;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R2 io_req raised", 32'(io_req), 32'd1);
    check(map_sparse ? "R4 sparse addr" : "R3 dense addr", 32'(io_addr),
          32'(exp_xlate(addr, map_sparse)));
    check("R12 io_we", 32'(io_we), 32'(we));
    check("R12 io_size", 32'(io_size), 32'(sz));
    if (we) check(big_endian ? "R6 write lanes" : "R5 write lanes", io_wdata,
                  exp_lane(wd, sz, big_endian));
    held = io_addr;
    for (int i = 0; i < dly; i++) begin
      if (stray && i == 0) begin
        cpu_req = 1'b1; cpu_addr = addr ^ 32'h0000_0F0F; cpu_we = ~we;
      end
      @(negedge clk);
      cpu_req = 1'b0;
      check("R2 held io_req", 32'(io_req), 32'd1);
      check("R11 addr unchanged", 32'(io_addr), 32'(held));
      check("R2 no early ready", 32'(cpu_ready), 32'd0);
    end
    io_ack = 1'b1; io_rdata = rd;
    @(negedge clk);
    io_ack = 1'b0; io_rdata = $urandom;
    check("R7 ready pulse", 32'(cpu_ready), 32'd1);
    check("R7 io_req dropped", 32'(io_req), 32'd0);
    if (!we) check(big_endian ? "R6 read lanes" : "R5 read lanes", cpu_rdata,
                   exp_lane(rd, sz, big_endian));
    @(negedge clk);
    check("R11 single ready", 32'(cpu_ready), 32'd0);
    check("R11 no second access", 32'(io_req), 32'd0);
  endtask

  task automatic flat_access(input string req, input logic we, input logic [31:0] addr,
                             input logic [1:0] sz, input logic exp_rdy,
                             input logic [31:0] exp_rd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz;
    @(negedge clk);
    cpu_req = 1'b0;
    check({req, " ready"}, 32'(cpu_ready), 32'(exp_rdy));
    check({req, " err"}, 32'(cpu_err), 32'(!exp_rdy));
    check({req, " no io_req"}, 32'(io_req), 32'd0);
    if (exp_rdy && !we) check({req, " rdata"}, cpu_rdata, exp_rd);
    @(negedge clk);
    check({req, " pulse ends"}, 32'(cpu_ready | cpu_err), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 io_req in reset", 32'(io_req), 32'd0);
    check("R1 ready in reset", 32'(cpu_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 io_req after reset", 32'(io_req), 32'd0);
    check("R1 err after reset", 32'(cpu_err), 32'd0);

    // Dense mode, little then big endian
    map_sparse = 1'b0; big_endian = 1'b0;
    io_access(1'b0, 32'h8000_1234, 2'd2, 32'h0, 32'h1122_3344, 1, 1'b0);
    io_access(1'b1, 32'h807F_ABCD, 2'd3, 32'hA1B2_C3D4, 32'h0, 0, 1'b0);
    big_endian = 1'b1;
    io_access(1'b0, 32'h8000_0061, 2'd2, 32'h0, 32'h1122_3344, 2, 1'b0);
    io_access(1'b0, 32'h8000_0062, 2'd1, 32'h0, 32'hFFFF_5566, 0, 1'b0);
    io_access(1'b1, 32'h8000_0063, 2'd0, 32'hDEAD_BE77, 32'h0, 0, 1'b0);
    io_access(1'b1, 32'h8000_0064, 2'd1, 32'hDEAD_BEEF, 32'h0, 1, 1'b0);
    // Sparse mode, fold boundaries
    map_sparse = 1'b1;
    io_access(1'b0, 32'h807F_F01F, 2'd2, 32'h0, 32'hCAFE_F00D, 0, 1'b0);
    io_access(1'b1, 32'h8000_1FE0, 2'd2, 32'h0102_0304, 32'h0, 0, 1'b0);
    io_access(1'b0, 32'h8012_3FFF, 2'd0, 32'h0, 32'h0000_00A5, 1, 1'b0);
    // Stray request while outstanding
    io_access(1'b0, 32'h8000_4321, 2'd2, 32'h0, 32'h5A5A_0F0F, 3, 1'b1);

    // Acknowledge region
    iack_vec = 8'h2C;
    big_endian = 1'b1;
    flat_access("R8 vec byte be", 1'b0, 32'hBFFF_FFF0, 2'd0, 1'b1, 32'h0000_002C);
    flat_access("R8 vec half be", 1'b0, 32'hBFFF_FFF0, 2'd1, 1'b1, 32'h0000_2C00);
    flat_access("R8 vec word be", 1'b0, 32'hBFFF_FFF0, 2'd2, 1'b1, 32'h2C00_0000);
    big_endian = 1'b0;
    flat_access("R8 vec word le", 1'b0, 32'hBFFF_FFF0, 2'd2, 1'b1, 32'h0000_002C);
    for (int k = 1; k < 4; k++)
      flat_access("R9 other byte", 1'b0, 32'hBFFF_FFF0 + 32'(k), 2'd0, 1'b1, 32'h0);
    flat_access("R9 write ignored", 1'b1, 32'hBFFF_FFF0, 2'd2, 1'b1, 32'h0);
    flat_access("R9 write ignored b3", 1'b1, 32'hBFFF_FFF3, 2'd0, 1'b1, 32'h0);

    // Unmapped
    flat_access("R10 low", 1'b0, 32'h0000_1000, 2'd2, 1'b0, 32'h0);
    flat_access("R10 past window", 1'b1, 32'h8080_0000, 2'd2, 1'b0, 32'h0);
    flat_access("R10 below window", 1'b0, 32'h7FFF_FFFF, 2'd0, 1'b0, 32'h0);
    flat_access("R10 after iack", 1'b0, 32'hBFFF_FFF4, 2'd2, 1'b0, 32'h0);
    flat_access("R10 before iack", 1'b0, 32'hBFFF_FFEF, 2'd0, 1'b0, 32'h0);

    // Random window traffic
    for (int n = 0; n < 80; n++) begin
      map_sparse = 1'($urandom);
      big_endian = 1'($urandom);
      io_access(1'($urandom), {9'h100, 23'($urandom)}, 2'($urandom), $urandom,
                $urandom, int'($urandom_range(0, 3)), (n % 7) == 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule